// File: doc/BRIEF.md
# Cross-Domain Sticky Event Status Register

This block collects single-cycle event pulses produced in a slower byte-clock domain and keeps them as sticky status bits in the faster system-clock domain. Each event line passes through a two-stage synchroniser. The synchronised result then sets a status bit. The bit stays set until software writes a 1 to its position, which makes the register write-one-to-clear. Reads see every bit at once on a parallel output.

A slow-domain pulse covers many system-clock cycles. If software reads a bit and clears it while the synchronised pulse is still high, a level-set register sets that bit again on the next cycle. The block reproduces this behaviour in level mode. A mode input selects edge mode instead. In edge mode only the rising edge of the synchronised event sets the bit, so one event sets the bit once, and a clear issued during the rest of the pulse takes effect.

Top module: `ssr_status_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, every bit of status_o becomes 0 at that edge.
- R2: When an event input bit goes from 0 to 1 and is held high, the matching status_o bit reads 1 after the third rising edge that samples it high, and not before. This latency comes from a two-stage synchroniser plus the status register.
- R3: Once a status bit is set, it stays 1 for as long as no clearing write addresses it, whatever the event input does.
- R4: A write (wr_en_i = 1) clears, at the next edge, each status bit whose wr_clr_i bit is 1 and that is not being set in the same cycle. Bits written with 0 keep their value.
- R5: If a set and a clear reach the same bit in the same cycle, the bit ends up 1.
- R6: With edge_mode_i = 0 (level set), a bit sets on every cycle in which its synchronised event is high. A clear issued while that level is still high therefore leaves the bit at 1.
- R7: With edge_mode_i = 1 (edge set), a bit sets only in the cycle after its synchronised event rises. A clear issued later in the same event's high phase leaves the bit at 0 until the event next rises.
- R8: In edge mode, a new rising edge on an event that has been low sets the bit again.
- R9: While wr_en_i = 0, wr_clr_i has no effect on any status bit.
- R10: Each status bit follows only its own event input and its own clear bit. status_o presents all bits in parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | N | Event lines from the byte-clock domain (asynchronous to clk) |
| edge_mode_i | input | 1 | 0: set from synchronised level, 1: set on synchronised rising edge |
| wr_en_i | input | 1 | Write strobe for the clear register |
| wr_clr_i | input | N | Write data; a 1 clears the matching status bit |
| status_o | output | N | Sticky status bits, read in parallel |

## Verification
A wrong synchroniser depth shows at status_o as a bit that rises one cycle early or late after an event edge, so every event is checked in the exact cycle it should appear. A wrong mode decode shows within one cycle of a clear issued during a long event: the bit either comes back or stays down, against what the selected mode requires. A broken clear mask or a lost sticky hold shows as a status bit that changes in the cycle after a write that did not address it, or after an event has ended.

// File: rtl/ssr_pkg.sv
// Shared definitions for the sticky status register.
// Assumes: nothing beyond standard SystemVerilog.
package ssr_pkg;

    // How a synchronised event sets its sticky bit
    typedef enum logic {
        SET_ON_LEVEL = 1'b0,
        SET_ON_RISE  = 1'b1
    } set_mode_e;

    // Depth of the event synchroniser in system-clock stages
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Next sticky value: keep unless cleared, set dominates the clear
    function automatic logic sticky_next(input logic cur,
                                         input logic clr,
                                         input logic set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/ssr_sync.sv
// Multi-stage flip-flop synchroniser for a vector of independent event lines.
// Assumes each line is a level held at least one full system-clock period
// (true for byte-clock pulses when the system clock is faster). Lines are
// not related to each other, so no bus coherency is implied across bits.
module ssr_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [N-1:0] stage_q [STAGES];

    // First stage: capture the asynchronous lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_i;
        end
    end

    // Remaining stages: let metastability settle
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/ssr_set_gen.sv
// Turns synchronised event levels into per-bit set requests.
// Level mode passes the level through. Edge mode gives a one-cycle request
// on each 0->1 transition. Assumes sync_i is already in the clk domain.
module ssr_set_gen
    import ssr_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  set_mode_e    mode_i,
    input  logic [N-1:0] sync_i,
    output logic [N-1:0] set_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    // Remember last cycle's synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_i;
        end
    end

    // Per-bit rising edge and mode selection
    for (genvar b = 0; b < N; b++) begin : g_bit
        assign rise[b] = sync_i[b] & ~prev_q[b];

        // Pick the set source for this bit
        always_comb begin
            unique case (mode_i)
                SET_ON_RISE:  set_o[b] = rise[b];
                default:      set_o[b] = sync_i[b];
            endcase
        end
    end

endmodule

// File: rtl/ssr_sticky.sv
// Bank of sticky bits with write-one-to-clear.
// A clear applies only while the write strobe is high. A set in the same
// cycle overrides the clear. Assumes set_i and the write port share clk.
module ssr_sticky
    import ssr_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_clr_i,
    output logic [N-1:0] bits_o
);

    logic [N-1:0] clr;
    logic [N-1:0] bits_q;

    // Gate the clear mask with the write strobe
    assign clr = wr_en_i ? wr_clr_i : '0;

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Hold, clear or set one status bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[b] <= 1'b0;
            end else begin
                bits_q[b] <= sticky_next(bits_q[b], clr[b], set_i[b]);
            end
        end
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/ssr_status_top.sv
// Cross-domain sticky status register, top level.
// Chain: event synchroniser -> set generator (level or rising edge) ->
// sticky bits with write-one-to-clear. Assumes evt_i comes from a slower
// clock, so each pulse lasts at least one clk period.
module ssr_status_top
    import ssr_pkg::*;
#(
    parameter int unsigned N           = 8,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         edge_mode_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_clr_i,
    output logic [N-1:0] status_o
);

    logic [N-1:0] sync_lvl;
    logic [N-1:0] set_vec;
    set_mode_e    mode;

    // Decode the mode pin into the shared type
    assign mode = edge_mode_i ? SET_ON_RISE : SET_ON_LEVEL;

    ssr_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_i),
        .sync_o  (sync_lvl)
    );

    ssr_set_gen #(.N(N)) u_setgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .sync_i (sync_lvl),
        .set_o  (set_vec)
    );

    ssr_sticky #(.N(N)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .wr_en_i  (wr_en_i),
        .wr_clr_i (wr_clr_i),
        .bits_o   (status_o)
    );

endmodule

// File: rtl/ssr_status_chk.sv
// Property checker for ssr_status_top, attached with bind.
// Observes the top ports plus the synchroniser output and the set vector,
// which are driven by separate sub-blocks from the status register.
module ssr_status_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         edge_mode,
    input logic         wr_en,
    input logic [N-1:0] wr_data,
    input logic [N-1:0] status,
    input logic [N-1:0] sync_lvl,
    input logic [N-1:0] set_vec
);

    // R3: with no write, no set bit is lost
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((status & $past(status)) == $past(status)));

    // R4: cleared bits that were not being set read 0
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((status & $past(wr_data) & ~$past(set_vec)) == '0));

    // R5: a set request always lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R2: a bit only rises after a set request
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

    // R6: level mode keeps a bit set while its synchronised event is high
    p_level_reassert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> ((status & $past(sync_lvl)) == $past(sync_lvl)));

    // R7: edge mode never requests a set on two cycles in a row
    p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode |-> ((set_vec & $past(set_vec)) == '0));

    // R9: with no write, the clear data cannot drop a bit
    p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (status != '0)) |=> ((status & $past(status)) != '0));

endmodule

bind ssr_status_top ssr_status_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (edge_mode_i),
    .wr_en     (wr_en_i),
    .wr_data   (wr_clr_i),
    .status    (status_o),
    .sync_lvl  (sync_lvl),
    .set_vec   (set_vec)
);

// File: tb/sim_ssr_status_top.sv
module sim_ssr_status_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] evt;
    logic         mode;
    logic         wr_en;
    logic [N-1:0] wr_clr;
    logic [N-1:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Expected-value timeline derived from R2..R10
    logic [N-1:0] h1, h2, h3, exp_st;
    bit           model_on = 0;

    always #2 clk = ~clk;

    ssr_status_top #(.N(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .edge_mode_i (mode),
        .wr_en_i     (wr_en),
        .wr_clr_i    (wr_clr),
        .status_o    (status)
    );

    function automatic logic [N-1:0] set_req(input logic m,
                                             input logic [N-1:0] lvl,
                                             input logic [N-1:0] old);
        return m ? (lvl & ~old) : lvl;
    endfunction

    function automatic logic [N-1:0] next_exp(input logic [N-1:0] cur,
                                              input logic we,
                                              input logic [N-1:0] d,
                                              input logic [N-1:0] s);
        return (cur & ~(we ? d : '0)) | s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0; exp_st <= '0;
        end else begin
            h1 <= evt; h2 <= h1; h3 <= h2;
            exp_st <= next_exp(exp_st, wr_en, wr_clr, set_req(mode, h2, h3));
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: status=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive after a falling edge, sample after the next falling edge
    task automatic cyc(input logic [N-1:0] e, input logic we,
                       input logic [N-1:0] d);
        evt = e; wr_en = we; wr_clr = d;
        @(posedge clk);
        @(negedge clk);
        if (model_on) check("R10 model", status, exp_st);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_clr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] ev;
        int           hold [N];
        void'($urandom(32'h5EED_0017));
        mode = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 reset", status, '0);

        // R2: latency of three edges
        cyc(8'h01, 0, '0); check("R2 edge1", status, 8'h00);
        cyc(8'h01, 0, '0); check("R2 edge2", status, 8'h00);
        cyc(8'h01, 0, '0); check("R2 edge3", status, 8'h01);
        // R3: stays set after event ends
        repeat (8) cyc(8'h00, 0, '0);
        check("R3 sticky", status, 8'h01);
        // R9: data without strobe does nothing
        cyc(8'h00, 0, 8'hFF); check("R9 no strobe", status, 8'h01);
        // R10: second bit independent
        repeat (3) cyc(8'h80, 0, '0);
        check("R10 parallel", status, 8'h81);
        repeat (3) cyc(8'h00, 0, '0);
        // R4: clear bit 0 only
        cyc(8'h00, 1, 8'h01); check("R4 clear one", status, 8'h80);
        cyc(8'h00, 1, 8'h80); check("R4 clear other", status, 8'h00);

        // R6: level mode, clear during long event reasserts
        mode = 1'b0;
        repeat (4) cyc(8'h02, 0, '0);
        check("R6 set", status, 8'h02);
        cyc(8'h02, 1, 8'h02); check("R6 reassert", status, 8'h02);
        repeat (3) cyc(8'h00, 0, '0);
        cyc(8'h00, 1, 8'h02); check("R6 clear after end", status, 8'h00);

        // R7: edge mode, clear during long event holds
        mode = 1'b1;
        repeat (4) cyc(8'h04, 0, '0);
        check("R7 set", status, 8'h04);
        cyc(8'h04, 1, 8'h04); check("R7 clear holds", status, 8'h00);
        repeat (4) cyc(8'h04, 0, '0);
        check("R7 no reset while high", status, 8'h00);
        // R8: new edge sets again
        repeat (3) cyc(8'h00, 0, '0);
        repeat (3) cyc(8'h04, 0, '0);
        check("R8 new edge", status, 8'h04);
        cyc(8'h00, 1, 8'h04);
        check("R8 cleared", status, 8'h00);
        repeat (3) cyc(8'h00, 0, '0);

        // R5: clear aligned with the set cycle of a fresh edge
        cyc(8'h08, 0, '0);
        cyc(8'h08, 0, '0);
        cyc(8'h08, 1, 8'h08); check("R5 set wins", status, 8'h08);
        repeat (3) cyc(8'h00, 0, '0);
        cyc(8'h00, 1, 8'hFF); check("R4 clear all", status, 8'h00);

        // Random phase: slow-clock-like events held several cycles
        do_reset();
        model_on = 1;
        ev = '0;
        for (int b = 0; b < N; b++) hold[b] = 0;
        for (int i = 0; i < 3000; i++) begin
            for (int b = 0; b < N; b++) begin
                if (hold[b] == 0) begin
                    ev[b] = ($urandom % 3) == 0;
                    hold[b] = 1 + ($urandom % 12);
                end else begin
                    hold[b]--;
                end
            end
            if ((i % 200) == 0) mode = $urandom % 2;
            cyc(ev, ($urandom % 4) == 0, N'($urandom));
        end
        model_on = 0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule